// File: doc/BRIEF.md
# Multi-channel event timer

The block is a memory-mapped event timer. One free-running 64-bit main counter advances once per clock while a global run bit is set. Three comparator channels watch it, and each one raises an interrupt when the counter reaches that channel's comparator value. All control and status sits behind a plain 32-bit word bus with a write strobe. Reads are combinational from the registered state.

Each channel runs in one of two ways. In one-shot mode it fires once, when the counter equals the comparator. In periodic mode, each match advances the comparator by a stored period. The period is loaded through a two-write set-value handshake. A channel can limit its compare and accumulation to the low 32 bits. Its interrupt line is either a single-cycle pulse or a level that is held until software clears the pending bit by writing a one to it.

Software points the counter at a deadline by writing the comparator with "counter + delta". It acknowledges events through the pending register. It may also stop the counter and rewrite it, for example to zero it.

Top module: `evtmr_top`

## Requirements
- R1: The identity word at byte offset 0x000 reads {vendor[15:0], bit15=0, bit14=0, bit13=1, (channels-1) in bits 12:8, revision[7:0]}, which is 0x5EED_2201 by default. Offset 0x004 reads the tick period in femtoseconds, 69841279 by default. Unmapped offsets, the upper config word (+0x04) and the route word (+0x10) of a channel all read 0.
- R2: Bit 0 of the global control word (0x010) runs the main counter, which then adds one per clock and carries across all 64 bits. While that bit is 0 the counter holds its value.
- R3: The counter halves at 0x0F0 (low) and 0x0F4 (high) take writes only while the counter is stopped. A write while it runs is ignored.
- R4: The channel n config word lives at 0x100+0x20*n. Its bits are: 1 level mode, 2 interrupt enable, 3 periodic, 4 and 5 read-only 1 (periodic and 64-bit capable), 6 set-value, 8 force 32-bit, 13:9 a stored route field. Bits 0, 7 and 14-31 read 0.
- R5: With its enable set and the counter running, channel n sets pending bit n of the word at 0x020 one clock after the counter equals its comparator (0x108/0x10C + 0x20*n, low/high). A disabled channel never sets its bit. A one-shot channel fires only once.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: In edge mode irq[n] is high for exactly the one clock in which the pending bit gets set. In level mode irq[n] follows the pending bit while the channel is enabled.
- R8: In periodic mode with set-value armed, the first comparator write (high half, then the low half that ends the step) loads the comparator. The second loads the period and clears set-value.
- R9: On each periodic match the comparator advances by the period. In periodic mode, comparator writes made without set-value update only the period.
- R10: With force 32-bit set, only the low 32 bits of counter and comparator are compared, and the periodic advance wraps within the low 32 bits while the high half is kept. Without it, all 64 bits must match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per edge while running |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 12 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel interrupt outputs |

## Verification
The bench sweeps cycle by cycle around each expected match and predicts pulse times arithmetically. An off-by-one in the match-to-pending latency, or a pulse that lasts two clocks, shows up as a miscompare at a known cycle. Periodic runs check that the comparator accumulates at 5+7m and that later writes without set-value touch only the period; swapping the two handshake targets would move every pulse. A channel is run with its comparator 2^32 ahead, which detects a full-width compare where the low word alone should match. Another run crosses the 32-bit boundary, which exposes an advance that carries into the high half. The bench also writes the counter while it runs and writes zeros to the pending register, and expects both to change nothing.

// File: rtl/evtmr_pkg.sv
// Shared constants and types for the multi-channel event timer.
// Assumes word-aligned byte offsets on a 12-bit address bus.
package evtmr_pkg;
    parameter int WORD_W = 32;
    parameter int CNT_W  = 2 * WORD_W;
    parameter int ADDR_W = 12;
    parameter int ROUTE_W = 5;

    localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TICKFS = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_GCTRL  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h0F4;
    localparam int CH_BASE   = 'h100;
    localparam int CH_STRIDE = 'h20;
    localparam logic [4:0] SUB_CFG    = 5'h00;
    localparam logic [4:0] SUB_CMP_LO = 5'h08;
    localparam logic [4:0] SUB_CMP_HI = 5'h0C;

    // Per-channel writable configuration
    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               f32;
        logic               sv;
        logic               per;
        logic               ten;
        logic               lvl;
    } chan_cfg_t;
endpackage

// File: rtl/evtmr_counter.sv
// Main 64-bit counter. Counts one per clock while run is high and accepts
// half-word writes only while stopped. Assumes a synchronous active-low reset.
module evtmr_counter
    import evtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q
);
    // Advance while running, otherwise accept software loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            if (we_lo) cnt_q[WORD_W-1:0]     <= wdata;
            if (we_hi) cnt_q[CNT_W-1:WORD_W] <= wdata;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt_q == $past(cnt_q) + 1'b1));                 // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we_lo && !we_hi) |=> $stable(cnt_q));          // R2
endmodule

// File: rtl/evtmr_channel.sv
// One comparator channel: config, comparator, period, set-value handshake,
// match detection and the edge pulse. Assumes at most one bus write per cycle;
// a bus write to the comparator wins over a periodic advance in the same cycle.
module evtmr_channel
    import evtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              run,
    input  logic              cfg_we,
    input  logic              cmp_lo_we,
    input  logic              cmp_hi_we,
    input  logic [WORD_W-1:0] wdata,
    output chan_cfg_t         cfg_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              match,
    output logic              pulse_q
);
    logic [CNT_W-1:0] per_q;
    logic             step_q;
    logic             hi_to_cmp;
    logic             eq_lo;
    logic             eq_hi;

    // Compare the two halves separately so force 32-bit can drop the top
    always_comb begin
        eq_lo = (cnt[WORD_W-1:0] == cmp_q[WORD_W-1:0]);
        eq_hi = (cnt[CNT_W-1:WORD_W] == cmp_q[CNT_W-1:WORD_W]);
        match = run && cfg_q.ten && eq_lo && (cfg_q.f32 || eq_hi);
    end

    // Route a high-half write to the comparator or to the period
    always_comb hi_to_cmp = !cfg_q.per || (cfg_q.sv && !step_q);

    // Register updates: config, handshake, comparator loads and advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cmp_q   <= '1;
            per_q   <= '0;
            step_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= match && !cfg_q.lvl;
            if (cfg_we) begin
                cfg_q.lvl   <= wdata[1];
                cfg_q.ten   <= wdata[2];
                cfg_q.per   <= wdata[3];
                cfg_q.sv    <= wdata[6];
                cfg_q.f32   <= wdata[8];
                cfg_q.route <= wdata[13:9];
                step_q      <= 1'b0;
            end else if (cmp_lo_we) begin
                if (!cfg_q.per) begin
                    cmp_q[WORD_W-1:0] <= wdata;
                end else if (cfg_q.sv && !step_q) begin
                    cmp_q[WORD_W-1:0] <= wdata;
                    step_q <= 1'b1;
                end else if (cfg_q.sv) begin
                    per_q[WORD_W-1:0] <= wdata;
                    cfg_q.sv <= 1'b0;
                    step_q   <= 1'b0;
                end else begin
                    per_q[WORD_W-1:0] <= wdata;
                end
            end else if (cmp_hi_we) begin
                if (hi_to_cmp) cmp_q[CNT_W-1:WORD_W] <= wdata;
                else           per_q[CNT_W-1:WORD_W] <= wdata;
            end else if (match && cfg_q.per) begin
                if (cfg_q.f32)
                    cmp_q[WORD_W-1:0] <= cmp_q[WORD_W-1:0] + per_q[WORD_W-1:0];
                else
                    cmp_q <= cmp_q + per_q;
            end
        end
    end

    AST_SV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_we && !cfg_we && cfg_q.per && cfg_q.sv && step_q) |=> !cfg_q.sv); // R8
    AST_PER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (match && cfg_q.per && !cfg_q.f32 && !cfg_we && !cmp_lo_we && !cmp_hi_we)
        |=> (cmp_q == $past(cmp_q) + $past(per_q)));              // R9
    AST_F32_HIKEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (match && cfg_q.per && cfg_q.f32 && !cfg_we && !cmp_lo_we && !cmp_hi_we)
        |=> $stable(cmp_q[CNT_W-1:WORD_W]));                      // R10
endmodule

// File: rtl/evtmr_top.sv
// Multi-channel event timer top: bus decode, global control, pending
// register with write-one-to-clear, read mux and interrupt outputs.
// Assumes word-aligned accesses and one write per clock.
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [15:0] VENDOR_ID = 16'h5EED,
    parameter logic [7:0]  REV_ID    = 8'h01,
    parameter logic [31:0] TICK_FS   = 32'd69841279
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [4:0]  CH_LAST = 5'(NUM_CH - 1);
    localparam logic [31:0] IDENT_WORD = {VENDOR_ID, 1'b0, 1'b0, 1'b1, CH_LAST, REV_ID};

    logic              run_q;
    logic              legacy_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] match_v;
    logic [NUM_CH-1:0] pulse_v;
    logic [NUM_CH-1:0] ch_hit;
    logic [CNT_W-1:0]  cnt;
    chan_cfg_t         cfg_v [NUM_CH];
    logic [CNT_W-1:0]  cmp_v [NUM_CH];

    // Global control word: run bit and a stored legacy-select bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            legacy_q <= 1'b0;
        end else if (bus_wr && bus_addr == OFS_GCTRL) begin
            run_q    <= bus_wdata[0];
            legacy_q <= bus_wdata[1];
        end
    end

    evtmr_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .we_lo (bus_wr && bus_addr == OFS_CNT_LO),
        .we_hi (bus_wr && bus_addr == OFS_CNT_HI),
        .wdata (bus_wdata),
        .cnt_q (cnt)
    );

    // Clear mask from a write to the pending word
    always_comb clr = (bus_wr && bus_addr == OFS_PEND) ? bus_wdata[NUM_CH-1:0] : '0;

    // Pending bits: a new match wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | match_v;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(CH_BASE + CH_STRIDE * n);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(CH_BASE + CH_STRIDE * (n + 1) - 1);

        assign ch_hit[n] = (bus_addr >= LO) && (bus_addr <= HI);

        evtmr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .run       (run_q),
            .cfg_we    (bus_wr && ch_hit[n] && bus_addr[4:0] == SUB_CFG),
            .cmp_lo_we (bus_wr && ch_hit[n] && bus_addr[4:0] == SUB_CMP_LO),
            .cmp_hi_we (bus_wr && ch_hit[n] && bus_addr[4:0] == SUB_CMP_HI),
            .wdata     (bus_wdata),
            .cfg_q     (cfg_v[n]),
            .cmp_q     (cmp_v[n]),
            .match     (match_v[n]),
            .pulse_q   (pulse_v[n])
        );

        // Output select: held level or single-cycle pulse
        assign irq[n] = cfg_v[n].lvl ? (pend_q[n] && cfg_v[n].ten) : pulse_v[n];

        AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
            match_v[n] |=> pend_q[n]);                                // R5
        AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[n] && !clr[n]) |=> pend_q[n]);                    // R6
        AST_EDGE_TIE: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_v[n].lvl && irq[n]) |-> pend_q[n]);                 // R7
    end

    // Read mux over global words and channel words
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IDENT:  bus_rdata = IDENT_WORD;
            OFS_TICKFS: bus_rdata = TICK_FS;
            OFS_GCTRL:  bus_rdata = {30'b0, legacy_q, run_q};
            OFS_PEND:   bus_rdata = WORD_W'(pend_q);
            OFS_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
            OFS_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD_W];
            default:    bus_rdata = '0;
        endcase
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                case (bus_addr[4:0])
                    SUB_CFG:    bus_rdata = {16'b0, 2'b00, cfg_v[n].route, cfg_v[n].f32,
                                             1'b0, cfg_v[n].sv, 2'b11, cfg_v[n].per,
                                             cfg_v[n].ten, cfg_v[n].lvl, 1'b0};
                    SUB_CMP_LO: bus_rdata = cmp_v[n][WORD_W-1:0];
                    SUB_CMP_HI: bus_rdata = cmp_v[n][CNT_W-1:WORD_W];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/sim_evtmr_top.sv
// Self-checking bench: cycle sweeps around predicted matches.
module sim_evtmr_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    int checks = 0;
    int fails = 0;

    evtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] cfg_a(input int n);
        return 12'(32'h100 + 32 * n);
    endfunction

    task automatic wcmp(input int n, input logic [63:0] v);
        wr(cfg_a(n) + 12'h0C, v[63:32]);
        wr(cfg_a(n) + 12'h08, v[31:0]);
    endtask

    task automatic prep();
        wr(12'h010, 0);
        wr(12'h0F0, 0);
        wr(12'h0F4, 0);
        for (int n = 0; n < 3; n++) wr(cfg_a(n), 0);
        wr(12'h020, 32'h7);
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(negedge clk);
        // Reset state and identity words
        rd(12'h000, d); chk("R1 ident", d, 32'h5EED_2201);
        rd(12'h004, d); chk("R1 tick period", d, 32'd69841279);
        rd(12'h010, d); chk("R2 gctrl reset", d, 0);
        rd(12'h020, d); chk("R5 pending reset", d, 0);
        rd(12'h0F0, d); chk("R2 counter reset", d, 0);
        chk("R7 irq reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h104, d); chk("R1 cfg upper word", d, 0);
        rd(12'h110, d); chk("R1 route word", d, 0);
        rd(12'h200, d); chk("R1 unmapped", d, 0);
        rd(cfg_a(1), d); chk("R4 cfg reset caps", d, 32'h0030);

        // R4 config field layout
        wr(cfg_a(1), 32'hFFFF_FFFF);
        rd(cfg_a(1), d); chk("R4 cfg all ones", d, 32'h3F7E);
        prep();
        rd(cfg_a(1), d); chk("R4 cfg cleared", d, 32'h0030);

        // R2/R3 counter run, hold, write rules
        wr(12'h010, 1);
        repeat (37) @(negedge clk);
        rd(12'h0F0, d); chk("R2 count 37", d, 37);
        wr(12'h0F0, 32'h1234);
        rd(12'h0F0, d); chk("R3 write ignored while running", d, 38);
        wr(12'h010, 0);
        repeat (10) @(negedge clk);
        rd(12'h0F0, d); chk("R2 hold when stopped", d, 39);
        wr(12'h0F0, 32'hDEAD_BEEF);
        wr(12'h0F4, 32'h5);
        rd(12'h0F0, d); chk("R3 low load", d, 32'hDEAD_BEEF);
        rd(12'h0F4, d); chk("R3 high load", d, 5);
        wr(12'h0F0, 32'hFFFF_FFFE);
        wr(12'h010, 1);
        repeat (3) @(negedge clk);
        rd(12'h0F0, d); rd(12'h0F4, d2);
        chk("R2 carry 64-bit", {d2, d}, 64'h6_0000_0001);

        // R5/R7 one-shot edge on channel 0, cmp 20
        prep();
        wcmp(0, 64'd20);
        wr(cfg_a(0), 32'h4);
        wr(12'h010, 1);
        for (int k = 0; k <= 40; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R7 edge pulse k=%0d", k), irq[0], (k == 21));
            rd(12'h020, d);
            chk($sformatf("R5 pending k=%0d", k), d[0], (k >= 21));
        end
        wr(12'h020, 32'h0);
        rd(12'h020, d); chk("R6 zero write keeps", d[0], 1);
        wr(12'h020, 32'h1);
        rd(12'h020, d); chk("R6 one clears", d[0], 0);

        // R5 disabled channel does not set pending
        prep();
        wcmp(1, 64'd8);
        wr(12'h010, 1);
        repeat (15) @(negedge clk);
        rd(12'h020, d); chk("R5 disabled channel silent", d, 0);

        // R7 level mode on channel 1, cmp 10
        prep();
        wcmp(1, 64'd10);
        wr(cfg_a(1), 32'h6);
        wr(12'h010, 1);
        for (int k = 0; k <= 20; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R7 level k=%0d", k), irq[1], (k >= 11));
        end
        wr(12'h020, 32'h0);
        chk("R7 level held after zero write", irq[1], 1);
        wr(12'h020, 32'h2);
        chk("R7 level drops on clear", irq[1], 0);

        // R8/R9 periodic handshake: cmp 5, period 7
        prep();
        wr(cfg_a(2), 32'h4C);
        wcmp(2, 64'd5);
        wcmp(2, 64'd7);
        rd(cfg_a(2), d); chk("R8 set-value self-clears", d, 32'h3C);
        rd(cfg_a(2) + 12'h08, d); chk("R8 first write is compare", d, 5);
        wr(12'h010, 1);
        for (int k = 0; k <= 30; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R9 periodic k=%0d", k), irq[2], (k >= 6 && (k - 6) % 7 == 0));
        end
        wr(12'h010, 0);
        rd(cfg_a(2) + 12'h08, d); chk("R9 accumulated compare", d, 33);
        wcmp(2, 64'd9);
        rd(cfg_a(2) + 12'h08, d); chk("R9 plain write goes to period", d, 33);
        wr(12'h010, 1);
        for (int k = 0; k <= 15; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R9 new period k=%0d", k), irq[2], (k == 3 || k == 12));
        end

        // R10 full 64-bit compare vs force 32-bit
        prep();
        wcmp(0, 64'h1_0000_001E);
        wr(cfg_a(0), 32'h4);
        wr(12'h010, 1);
        for (int k = 0; k <= 40; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R10 64-bit no match k=%0d", k), irq[0], 0);
        end
        prep();
        wr(cfg_a(0), 32'h104);
        wr(12'h010, 1);
        for (int k = 0; k <= 40; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R10 force32 match k=%0d", k), irq[0], (k == 31));
        end

        // R10 periodic wrap in low word across the 32-bit boundary
        prep();
        wr(12'h0F0, 32'hFFFF_FFE0);
        wr(cfg_a(1), 32'h14C);
        wcmp(1, 64'h0000_0000_FFFF_FFF0);
        wcmp(1, 64'h20);
        wr(12'h010, 1);
        for (int k = 0; k <= 60; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R10 wrap k=%0d", k), irq[1], (k == 17 || k == 49));
        end
        rd(cfg_a(1) + 12'h08, d); chk("R10 low word wrapped", d, 32'h30);
        rd(cfg_a(1) + 12'h0C, d); chk("R10 high word kept", d, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule